// File: doc/BRIEF.md
# Three-Slot Early-Stall Flit Output Buffer

This block sits at an output port of a router and feeds a flit channel. The stage upstream of it decides to send a flit one cycle before the flit arrives, because it samples the buffer's ready signal one clock late. A flit can therefore still be in transit after ready has dropped. To handle this, the buffer withdraws ready as soon as two flits are stored, and it keeps a third slot to catch the flit that is in transit.

Storage is a three-entry register file. A rotating one-hot pointer selects the slot to write and another selects the slot to read. Combinational logic derives the handshake from the occupancy count and from one registered copy of ready.

Back-pressure rules:
- On the input side, an upstream stage may raise `in_valid` only in a cycle that follows a cycle in which `in_ready` was high. Every cycle with `in_valid` high writes one flit.
- On the output side, a flit leaves on a rising edge when `out_valid` and `out_ready` are both high.
- While `out_ready` is low, the head flit is held.

Top module: `flit_outbuf3`

## Requirements
- R1: During and directly after a synchronous reset (`rst` high), the buffer is empty. `out_valid` is 0, `in_ready` is 1, and both pointers select slot 0.
- R2: Each rising edge with `in_valid` high stores `in_data`. The upstream may raise `in_valid` only in a cycle that follows one with `in_ready` high. Every flit stored is later delivered exactly once.
- R3: Flits leave in arrival order, and `out_data` is the oldest stored flit. While `out_valid` is high and `out_ready` is low, `out_data` and `out_valid` stay unchanged.
- R4: `out_valid` is high exactly when the occupancy is 1, 2 or 3.
- R5: With two flits stored, `in_ready` is low if it was high in the previous cycle.
- R6: With two flits stored, `in_ready` is high if it was low in the previous cycle. This happens because no flit can be in transit.
- R7: With three flits stored, `in_ready` is low. A write never finds all three slots full.
- R8: A cycle that both writes and reads leaves the occupancy unchanged.
- R9: With zero or one flit stored, `in_ready` is high.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge active |
| rst | input | 1 | Synchronous reset, active high |
| in_data | input | DATA_W | Flit arriving from the upstream stage |
| in_valid | input | 1 | Flit on in_data is written at this edge |
| in_ready | output | 1 | Upstream may send a flit in the next cycle |
| out_data | output | DATA_W | Oldest stored flit |
| out_valid | output | 1 | out_data holds a flit |
| out_ready | input | 1 | Channel accepts the flit this edge |

## Verification
The bench stalls the output until the buffer holds three flits and ready stays low. It then releases one flit, which exercises the one-cycle re-assert at two stored flits and the drop that follows it.

Failure modes each phase exposes:
- A design that never re-asserts ready would hang at two flits.
- A design that keeps ready high at two flits would overflow on the in-transit flit.
- A pointer that rotates on the wrong event would deliver flits out of order or repeat them.

Long random phases mix simultaneous reads and writes at every occupancy. A reference occupancy model predicts ready and valid in every cycle.

// File: rtl/flit_outbuf_pkg.sv
package flit_outbuf_pkg;
  localparam int unsigned SLOT_COUNT = 3;
  localparam int unsigned OCC_W      = $clog2(SLOT_COUNT + 1);
  localparam int unsigned STALL_AT   = SLOT_COUNT - 1;
endpackage

// File: rtl/flit_outbuf_ring.sv
module flit_outbuf_ring #(
  parameter int unsigned N = 3
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         step,
  output logic [N-1:0] sel
);
  always_ff @(posedge clk) begin
    if (rst)       sel <= N'(1);
    else if (step) sel <= {sel[N-2:0], sel[N-1]};
  end

  // R3: a pointer always names exactly one slot
  p_onehot_r3: assert property (@(posedge clk) disable iff (rst)
    $countones(sel) == 1);
endmodule

// File: rtl/flit_outbuf_slots.sv
module flit_outbuf_slots #(
  parameter int unsigned W = 16,
  parameter int unsigned N = 3
) (
  input  logic         clk,
  input  logic         wr_en,
  input  logic [N-1:0] wr_sel,
  input  logic [W-1:0] wr_data,
  input  logic [N-1:0] rd_sel,
  output logic [W-1:0] rd_data
);
  logic [W-1:0] mem [N];

  for (genvar g = 0; g < N; g++) begin : g_slot
    always_ff @(posedge clk) begin
      if (wr_en && wr_sel[g]) mem[g] <= wr_data;
    end
  end

  always_comb begin
    rd_data = '0;
    for (int i = 0; i < N; i++) begin
      if (rd_sel[i]) rd_data = rd_data | mem[i];
    end
  end
endmodule

// File: rtl/flit_outbuf_ctl.sv
module flit_outbuf_ctl
  import flit_outbuf_pkg::*;
(
  input  logic             clk,
  input  logic             rst,
  input  logic             push,
  input  logic             pop,
  output logic [OCC_W-1:0] occ,
  output logic             in_ready,
  output logic             out_valid
);
  logic rdy_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      occ   <= '0;
      rdy_q <= 1'b1;
    end else begin
      rdy_q <= in_ready;
      case ({push, pop})
        2'b10:   occ <= occ + 1'b1;
        2'b01:   occ <= occ - 1'b1;
        default: occ <= occ;
      endcase
    end
  end

  always_comb begin
    out_valid = (occ != '0);
    in_ready  = (occ < OCC_W'(STALL_AT)) || ((occ == OCC_W'(STALL_AT)) && !rdy_q);
  end

  // R7: a write never meets a full buffer
  p_no_overflow_r7: assert property (@(posedge clk) disable iff (rst)
    push |-> (occ < OCC_W'(SLOT_COUNT)));

  // R8: simultaneous read and write keeps occupancy
  p_steady_occ_r8: assert property (@(posedge clk) disable iff (rst)
    (push && pop) |=> (occ == $past(occ)));

  // R5: a ready at the stall level is followed by a stall unless occupancy fell
  p_ready_pulse_r5: assert property (@(posedge clk) disable iff (rst)
    (in_ready && occ == OCC_W'(STALL_AT) && !pop) |=> !in_ready);

  // R6: a stall at the stall level with unchanged occupancy gives ready back
  p_reassert_r6: assert property (@(posedge clk) disable iff (rst)
    (!in_ready && occ == OCC_W'(STALL_AT) && (push == pop)) |=> in_ready);
endmodule

// File: rtl/flit_outbuf3.sv
module flit_outbuf3
  import flit_outbuf_pkg::*;
#(
  parameter int unsigned DATA_W = 16
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [DATA_W-1:0] in_data,
  input  logic              in_valid,
  output logic              in_ready,
  output logic [DATA_W-1:0] out_data,
  output logic              out_valid,
  input  logic              out_ready
);
  logic [SLOT_COUNT-1:0] wr_sel;
  logic [SLOT_COUNT-1:0] rd_sel;
  logic [OCC_W-1:0]      occ;
  logic                  pop;

  assign pop = out_valid && out_ready;

  flit_outbuf_ring #(.N(SLOT_COUNT)) u_wr_ptr (
    .clk(clk), .rst(rst), .step(in_valid), .sel(wr_sel)
  );

  flit_outbuf_ring #(.N(SLOT_COUNT)) u_rd_ptr (
    .clk(clk), .rst(rst), .step(pop), .sel(rd_sel)
  );

  flit_outbuf_slots #(.W(DATA_W), .N(SLOT_COUNT)) u_slots (
    .clk(clk), .wr_en(in_valid), .wr_sel(wr_sel), .wr_data(in_data),
    .rd_sel(rd_sel), .rd_data(out_data)
  );

  flit_outbuf_ctl u_ctl (
    .clk(clk), .rst(rst), .push(in_valid), .pop(pop),
    .occ(occ), .in_ready(in_ready), .out_valid(out_valid)
  );

  // R2: upstream commits a flit only after seeing ready one cycle earlier
  p_upstream_r2: assert property (@(posedge clk) disable iff (rst)
    in_valid |-> $past(in_ready));

  // R3: a stalled head flit is held
  p_hold_r3: assert property (@(posedge clk) disable iff (rst)
    (out_valid && !out_ready) |=> (out_valid && $stable(out_data)));

  // R7: ready is never offered with all slots taken
  p_full_stall_r7: assert property (@(posedge clk) disable iff (rst)
    (occ == OCC_W'(SLOT_COUNT)) |-> !in_ready);
endmodule

// File: tb/flit_outbuf3_bench.sv
module flit_outbuf3_bench;
  localparam int unsigned DW = 16;

  logic          clk = 1'b0;
  logic          rst;
  logic [DW-1:0] in_data;
  logic          in_valid;
  logic          in_ready;
  logic [DW-1:0] out_data;
  logic          out_valid;
  logic          out_ready;

  int checks = 0;
  int errors = 0;
  logic [DW-1:0] exp_q [$];
  logic [DW-1:0] next_val = 16'h0100;
  logic          last_rdy = 1'b0;
  bit            finished = 1'b0;

  always #10 clk = ~clk;

  flit_outbuf3 #(.DATA_W(DW)) u_flit_outbuf3 (
    .clk(clk), .rst(rst), .in_data(in_data), .in_valid(in_valid),
    .in_ready(in_ready), .out_data(out_data), .out_valid(out_valid),
    .out_ready(out_ready)
  );

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h at %0t", req, act, exp, $time);
    end
  endtask

  // Driver (R2): upstream commits a flit only if ready was seen last cycle
  task automatic drive(input bit want_send, input bit rdy);
    @(negedge clk);
    in_valid  = last_rdy && want_send;
    out_ready = rdy;
    if (in_valid) begin
      in_data = next_val;
      exp_q.push_back(next_val);
      next_val = next_val + 16'd1;
    end
    last_rdy = in_ready;
  endtask

  // Monitor: reference occupancy model and scoreboard
  int m_occ  = 0;
  bit m_prev = 1'b1;
  always @(negedge clk) begin
    #5;
    if (rst) begin
      m_occ  = 0;
      m_prev = 1'b1;
    end else begin
      bit exp_rdy;
      bit fire;
      exp_rdy = (m_occ < 2) || (m_occ == 2 && !m_prev);
      if (m_occ < 2)       chk(in_ready == exp_rdy, "R9 ready below two", in_ready, exp_rdy);
      else if (m_occ == 3) chk(in_ready == exp_rdy, "R7 ready at full", in_ready, exp_rdy);
      else if (!m_prev)    chk(in_ready == exp_rdy, "R6 ready re-assert", in_ready, exp_rdy);
      else                 chk(in_ready == exp_rdy, "R5 early stall", in_ready, exp_rdy);
      chk(out_valid == (m_occ != 0), "R4 out_valid", out_valid, m_occ != 0);
      fire = out_valid && out_ready;
      if (fire) begin
        if (exp_q.size() == 0) chk(1'b0, "R3 unexpected flit", out_data, 0);
        else begin
          logic [DW-1:0] e;
          e = exp_q.pop_front();
          chk(out_data == e, "R3 order", out_data, e);
        end
      end
      chk(m_occ + int'(in_valid) - int'(fire) <= 3, "R7 occupancy bound",
          m_occ + int'(in_valid) - int'(fire), 3);
      // R8: both events together leave the count alone
      m_occ  = m_occ + int'(in_valid) - int'(fire);
      m_prev = exp_rdy;
    end
  end

  initial begin
    rst = 1'b1; in_valid = 1'b0; out_ready = 1'b0; in_data = '0;
    repeat (4) @(negedge clk);
    rst = 1'b0;
    #5;
    chk(out_valid == 1'b0, "R1 reset out_valid", out_valid, 0);
    chk(in_ready == 1'b1, "R1 reset in_ready", in_ready, 1);
    last_rdy = in_ready;

    repeat (20) drive(1'b1, 1'b1);        // streaming
    repeat (8)  drive(1'b1, 1'b0);        // fill with output stalled
    #5;
    chk(in_ready == 1'b0, "R7 full stall", in_ready, 0);
    chk(out_valid == 1'b1, "R4 full valid", out_valid, 1);

    drive(1'b0, 1'b1);                     // release one flit
    drive(1'b0, 1'b0);
    #5;
    chk(in_ready == 1'b1, "R6 pulse", in_ready, 1);
    drive(1'b0, 1'b0);
    #5;
    chk(in_ready == 1'b0, "R5 stall after pulse", in_ready, 0);

    for (int i = 0; i < 3000; i++) begin
      case ((i / 500) % 3)
        0:       drive(($urandom % 4) != 0, ($urandom % 3) != 0);
        1:       drive(($urandom % 2) != 0, ($urandom % 4) == 0);
        default: drive(1'b1, ($urandom % 2) != 0);
      endcase
    end

    for (int i = 0; i < 20; i++) drive(1'b0, 1'b1);
    #5;
    chk(exp_q.size() == 0, "R2 all flits delivered", exp_q.size(), 0);
    chk(out_valid == 1'b0, "R4 empty after drain", out_valid, 0);

    finished = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!finished) begin
      checks++;
      errors++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end
endmodule